// File: doc/BRIEF.md
# Command Block Assembler and Status Port

This block sits behind a single 16-bit word port that a host uses in both directions. On the write side, the host first raises a command request naming a target device, then writes the words of a command block. The block collects either two or four words, depending on a size bit in the first word. It checks that the device field inside the block agrees with the request target and hands a decoded command to a downstream sequencer through a one-cycle start strobe and a set of registered fields.

On the read side, the sequencer loads a status block: a number of payload words plus an opcode and device for the header. The host then reads the port one word at a time. The first word is a header that the block composes itself; the payload follows in address order. After the last word has been read, the status-full flag drops and the queue empties itself. Reads of an empty queue return zero.

Top module: `cmd_stat_port`

## Requirements
- R1: Bit 14 of the first command word selects the block length: set means four words, clear means two words. No start strobe appears before the final word of the block has been written.
- R2: The device field of the first word (bits 7:5) is compared with the device given at the command request. On a mismatch, the final word raises `err_dev` for one cycle, no start strobe is issued, busy is not set, and the registered command fields keep their previous values.
- R3: When the final word of a matching block is written, `cmd_start` is high for exactly one cycle, `busy` goes high, and `req_pending` clears. All three are visible in the cycle after the write edge.
- R4: A command word written while no request is pending raises `err_overrun` for one cycle and is discarded. This includes a fifth word after a four-word block. The registered command fields do not change.
- R5: An accepted command sets the following fields, which hold until the next accepted command:
  - `cmd_opcode`: word 0 bits 4:0.
  - `cmd_device`: word 0 bits 7:5.
  - `cmd_count`: word 1.
  - `cmd_rba`: the low 28 bits of {word 3, word 2} for a four-word block, and zero for a two-word block.
- R6: A status commit with payload count N, opcode and device sets `status_full` and queues N+1 words. The first word is a header {N+1 in bits 15:8, device in bits 7:5, opcode in bits 4:0}. It is followed by the payload words stored at addresses 0 to N-1, in that order.
- R7: Each read returns the next queued word in the following cycle. The read that returns the last word clears `status_full` and empties the queue. A read of an empty queue returns 0x0000.
- R8: A status commit clears `busy`.
- R9: After reset, all outputs are zero: no pending request, not busy, status empty, read data 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attn_req | input | 1 | Command request strobe; opens a new command block |
| attn_dev | input | 3 | Device targeted by the command request |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 16 | Command word |
| rd_en | input | 1 | Status word read strobe |
| rd_data | output | 16 | Status word, valid the cycle after `rd_en` |
| st_we | input | 1 | Sequencer payload word write |
| st_addr | input | 4 | Payload word address |
| st_data | input | 16 | Payload word |
| st_commit | input | 1 | Publish the status block |
| st_len | input | 4 | Payload word count for the commit |
| st_op | input | 5 | Opcode for the status header |
| st_dev | input | 3 | Device for the status header |
| cmd_start | output | 1 | One-cycle start strobe to the sequencer |
| cmd_opcode | output | 5 | Opcode of the last accepted command |
| cmd_device | output | 3 | Device of the last accepted command |
| cmd_count | output | 16 | Block count of the last accepted command |
| cmd_rba | output | 28 | Relative block address of the last accepted command |
| req_pending | output | 1 | A command request is collecting words |
| busy | output | 1 | Command accepted; stays set until a status commit |
| status_full | output | 1 | Status words remain to be read |
| err_dev | output | 1 | One-cycle pulse: device field mismatch |
| err_overrun | output | 1 | One-cycle pulse: word written with no request pending |

## Verification
A word pointer that drifts would show up at the ports as a start strobe that comes one word early or late. It would also produce a count or address built from the wrong word; both are visible in the cycle after the final write. A wrong read pointer or length in the status queue would show as a header or payload word out of order, or as `status_full` dropping one read too early or too late. The trailing read that must return zero exposes it at once. A stale device target would produce either a false `err_dev` or a missing one on the same cycle as the start strobe would have come.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
   localparam int WORD_W   = 16;
   localparam int OPC_W    = 5;
   localparam int DEV_W    = 3;
   localparam int DEV_LSB  = 5;
   localparam int SIZE_BIT = 14;
   localparam int LEN_W    = 8;

   function automatic logic [WORD_W-1:0] make_hdr(input logic [LEN_W-1:0] n,
                                                  input logic [DEV_W-1:0] d,
                                                  input logic [OPC_W-1:0] o);
      return {n, d, o};
   endfunction
endpackage

// File: rtl/cbp_cmd_collect.sv
module cbp_cmd_collect
   import cbp_pkg::*;
#(
   parameter int RBA_W = 28
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 attn_req,
   input  logic [DEV_W-1:0]     attn_dev,
   input  logic                 wr_en,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic                 busy_clr,
   output logic                 cmd_start,
   output logic [OPC_W-1:0]     cmd_opcode,
   output logic [DEV_W-1:0]     cmd_device,
   output logic [WORD_W-1:0]    cmd_count,
   output logic [RBA_W-1:0]     cmd_rba,
   output logic                 req_pending,
   output logic                 busy,
   output logic                 err_dev,
   output logic                 err_overrun
);
   localparam int MAXW = 4;
   localparam int PW   = $clog2(MAXW);

   if (RBA_W < 1 || RBA_W > 2*WORD_W) begin : g_bad_rba
      $error("RBA_W must fit in two command words");
   end

   logic [PW-1:0]     wptr;
   logic [DEV_W-1:0]  tgt;
   logic [WORD_W-1:0] blk [MAXW];
   logic              take;

   assign take = wr_en && !attn_req && req_pending;

   // Word storage; blk shows the current write in place of the stored word
   for (genvar g = 0; g < MAXW; g++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                        q <= '0;
         else if (take && wptr == PW'(g))   q <= wr_data;
      end
      assign blk[g] = (wptr == PW'(g)) ? wr_data : q;
   end

   logic              size4, is_last, dev_ok;
   logic [PW-1:0]     last_ptr;
   logic [2*WORD_W-1:0] addr_pair;

   assign size4     = blk[0][SIZE_BIT];
   assign last_ptr  = size4 ? PW'(MAXW-1) : PW'(1);
   assign is_last   = (wptr == last_ptr);
   assign dev_ok    = (blk[0][DEV_LSB +: DEV_W] == tgt);
   assign addr_pair = {blk[3], blk[2]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr        <= '0;
         tgt         <= '0;
         req_pending <= 1'b0;
         busy        <= 1'b0;
         cmd_start   <= 1'b0;
         err_dev     <= 1'b0;
         err_overrun <= 1'b0;
         cmd_opcode  <= '0;
         cmd_device  <= '0;
         cmd_count   <= '0;
         cmd_rba     <= '0;
      end else begin
         cmd_start   <= 1'b0;
         err_dev     <= 1'b0;
         err_overrun <= 1'b0;
         if (busy_clr) busy <= 1'b0;
         if (attn_req) begin
            req_pending <= 1'b1;
            wptr        <= '0;
            tgt         <= attn_dev;
         end else if (wr_en) begin
            if (!req_pending) begin
               err_overrun <= 1'b1;
            end else if (is_last) begin
               wptr        <= '0;
               req_pending <= 1'b0;
               if (dev_ok) begin
                  cmd_start  <= 1'b1;
                  busy       <= 1'b1;
                  cmd_opcode <= blk[0][OPC_W-1:0];
                  cmd_device <= blk[0][DEV_LSB +: DEV_W];
                  cmd_count  <= blk[1];
                  cmd_rba    <= size4 ? addr_pair[RBA_W-1:0] : '0;
               end else begin
                  err_dev <= 1'b1;
               end
            end else begin
               wptr <= wptr + 1'b1;
            end
         end
      end
   end

   assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);
   assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> cmd_start);
   assert_mismatch_nostart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_dev |-> (!cmd_start && !req_pending));
   assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !attn_req && !req_pending) |=> (err_overrun && !cmd_start));
   assert_ptr_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_pending |-> (wptr == '0));
endmodule

// File: rtl/cbp_stat_queue.sv
module cbp_stat_queue
   import cbp_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PAW  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               st_we,
   input  logic [PAW-1:0]     st_addr,
   input  logic [WORD_W-1:0]  st_data,
   input  logic               st_commit,
   input  logic [PAW-1:0]     st_len,
   input  logic [OPC_W-1:0]   st_op,
   input  logic [DEV_W-1:0]   st_dev,
   input  logic               rd_en,
   output logic [WORD_W-1:0]  rd_data,
   output logic               status_full
);
   localparam int LW = PAW + 1;

   if (DEPTH < 2 || (1 << PAW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LW > LEN_W) begin : g_bad_len
      $error("DEPTH too large for the header length field");
   end

   logic [WORD_W-1:0] slot [DEPTH];
   logic [WORD_W-1:0] hdr;
   logic [LW-1:0]     len, rptr;
   logic [PAW-1:0]    pidx;
   logic [LW-1:0]     pm1;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                            q <= '0;
         else if (st_we && st_addr == PAW'(g))  q <= st_data;
      end
      assign slot[g] = q;
   end

   assign pm1  = rptr - 1'b1;
   assign pidx = pm1[PAW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len         <= '0;
         rptr        <= '0;
         hdr         <= '0;
         rd_data     <= '0;
         status_full <= 1'b0;
      end else if (st_commit) begin
         len         <= LW'(st_len) + 1'b1;
         rptr        <= '0;
         status_full <= 1'b1;
         hdr         <= make_hdr(LEN_W'(st_len) + 1'b1, st_dev, st_op);
      end else if (rd_en) begin
         if (len == '0) begin
            rd_data <= '0;
         end else begin
            rd_data <= (rptr == '0) ? hdr : slot[pidx];
            if (rptr == len - 1'b1) begin
               len         <= '0;
               rptr        <= '0;
               status_full <= 1'b0;
            end else begin
               rptr <= rptr + 1'b1;
            end
         end
      end
   end

   assert_commit_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st_commit |=> (status_full && len != '0));
   assert_drain_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !st_commit && len != '0 && rptr == len - 1'b1) |=> (!status_full && len == '0));
   assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !st_commit && len == '0) |=> (rd_data == '0));
   assert_full_tracks_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status_full |-> (rptr < len));
endmodule

// File: rtl/cmd_stat_port.sv
module cmd_stat_port
   import cbp_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int RBA_W = 28,
   localparam int PAW  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               attn_req,
   input  logic [2:0]         attn_dev,
   input  logic               wr_en,
   input  logic [15:0]        wr_data,
   input  logic               rd_en,
   output logic [15:0]        rd_data,
   input  logic               st_we,
   input  logic [PAW-1:0]     st_addr,
   input  logic [15:0]        st_data,
   input  logic               st_commit,
   input  logic [PAW-1:0]     st_len,
   input  logic [4:0]         st_op,
   input  logic [2:0]         st_dev,
   output logic               cmd_start,
   output logic [4:0]         cmd_opcode,
   output logic [2:0]         cmd_device,
   output logic [15:0]        cmd_count,
   output logic [RBA_W-1:0]   cmd_rba,
   output logic               req_pending,
   output logic               busy,
   output logic               status_full,
   output logic               err_dev,
   output logic               err_overrun
);
   cbp_cmd_collect #(.RBA_W(RBA_W)) u_collect (
      .clk(clk), .rst_n(rst_n),
      .attn_req(attn_req), .attn_dev(attn_dev),
      .wr_en(wr_en), .wr_data(wr_data),
      .busy_clr(st_commit),
      .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_device(cmd_device),
      .cmd_count(cmd_count), .cmd_rba(cmd_rba),
      .req_pending(req_pending), .busy(busy),
      .err_dev(err_dev), .err_overrun(err_overrun)
   );

   cbp_stat_queue #(.DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
      .st_commit(st_commit), .st_len(st_len), .st_op(st_op), .st_dev(st_dev),
      .rd_en(rd_en), .rd_data(rd_data), .status_full(status_full)
   );

   assert_commit_clears_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_commit && !(wr_en && req_pending && !attn_req)) |=> !busy);
endmodule

// File: tb/cmd_stat_port_tb.sv
module cmd_stat_port_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        attn_req = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  attn_dev = '0;
   logic [15:0] wr_data = '0, st_data = '0;
   logic        st_we = 1'b0, st_commit = 1'b0;
   logic [3:0]  st_addr = '0, st_len = '0;
   logic [4:0]  st_op = '0;
   logic [2:0]  st_dev = '0;
   logic [15:0] rd_data, cmd_count;
   logic        cmd_start, req_pending, busy, status_full, err_dev, err_overrun;
   logic [4:0]  cmd_opcode;
   logic [2:0]  cmd_device;
   logic [27:0] cmd_rba;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_stat_port dut_i (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [27:0] exp_rba(input bit s4, input logic [15:0] lo, input logic [15:0] hi);
      return s4 ? {hi[11:0], lo} : 28'd0;
   endfunction

   function automatic logic [15:0] exp_hdr(input int n, input logic [2:0] d, input logic [4:0] o);
      return {8'(n + 1), d, o};
   endfunction

   task automatic attn(input logic [2:0] d);
      @(negedge clk); attn_req = 1'b1; attn_dev = d;
      @(negedge clk); attn_req = 1'b0;
   endtask

   task automatic wr_word(input logic [15:0] w);
      @(negedge clk); wr_en = 1'b1; wr_data = w;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd_word();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic st_word(input logic [3:0] a, input logic [15:0] w);
      @(negedge clk); st_we = 1'b1; st_addr = a; st_data = w;
      @(negedge clk); st_we = 1'b0;
   endtask

   task automatic commit(input logic [3:0] n, input logic [4:0] o, input logic [2:0] d);
      @(negedge clk); st_commit = 1'b1; st_len = n; st_op = o; st_dev = d;
      @(negedge clk); st_commit = 1'b0;
   endtask

   logic [4:0]  e_op = '0;
   logic [2:0]  e_dev = '0;
   logic [15:0] e_cnt = '0;
   logic [27:0] e_rba = '0;

   task automatic held(input string req);
      chk(cmd_opcode == e_op && cmd_device == e_dev && cmd_count == e_cnt && cmd_rba == e_rba,
          req, {cmd_device, cmd_opcode, cmd_count}, {e_dev, e_op, e_cnt});
   endtask

   task automatic status_round(input int n, input logic [4:0] o, input logic [2:0] d);
      logic [15:0] pay [16];
      for (int i = 0; i < n; i++) begin
         pay[i] = 16'($urandom);
         st_word(4'(i), pay[i]);
      end
      commit(4'(n), o, d);
      chk(status_full == 1'b1, "R6 full after commit", status_full, 1);
      chk(busy == 1'b0, "R8 busy cleared by commit", busy, 0);
      rd_word();
      chk(rd_data == exp_hdr(n, d, o), "R6 header word", rd_data, exp_hdr(n, d, o));
      for (int i = 0; i < n; i++) begin
         chk(status_full == 1'b1, "R7 full before last word", status_full, 1);
         rd_word();
         chk(rd_data == pay[i], "R6 payload order", rd_data, pay[i]);
      end
      chk(status_full == 1'b0, "R7 full clears after last word", status_full, 0);
      rd_word();
      chk(rd_data == 16'h0000, "R7 empty read is zero", rd_data, 0);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(rd_data == 0 && !cmd_start && !busy && !req_pending && !status_full &&
          !err_dev && !err_overrun && cmd_rba == 0 && cmd_count == 0,
          "R9 reset state", {busy, req_pending, status_full}, 0);
      // R7 empty read
      rd_word();
      chk(rd_data == 0 && !status_full, "R7 read of empty queue", rd_data, 0);
      // R4 word without request
      wr_word(16'h4123);
      chk(err_overrun == 1'b1 && !cmd_start, "R4 write with no request", err_overrun, 1);
      held("R4 fields unchanged");
      // Directed 2-word block: rba must read zero
      attn(3'd1);
      chk(req_pending == 1'b1, "R3 pending after request", req_pending, 1);
      wr_word(16'h0025);
      chk(cmd_start == 1'b0, "R1 no start after first word", cmd_start, 0);
      wr_word(16'h0007);
      chk(cmd_start == 1'b1 && busy && !req_pending, "R3 start on 2nd word", cmd_start, 1);
      e_op = 5'h05; e_dev = 3'd1; e_cnt = 16'h0007; e_rba = '0;
      held("R5 two-word fields");
      @(negedge clk);
      chk(cmd_start == 1'b0, "R3 start one cycle only", cmd_start, 0);
      status_round(0, 5'h05, 3'd1);
      // Random mix
      for (int it = 0; it < 60; it++) begin
         bit          s4, mis;
         logic [2:0]  d, fd;
         logic [15:0] w [4];
         int          nw;
         s4  = 1'($urandom);
         mis = ($urandom % 4) == 0;
         d   = 3'($urandom);
         fd  = mis ? (d ^ 3'(1 + $urandom % 7)) : d;
         for (int k = 0; k < 4; k++) w[k] = 16'($urandom);
         w[0][14] = s4;
         w[0][7:5] = fd;
         nw = s4 ? 4 : 2;
         attn(d);
         for (int k = 0; k < nw; k++) begin
            wr_word(w[k]);
            if (k < nw - 1)
               chk(cmd_start == 1'b0 && !err_dev, "R1 no early start", cmd_start, 0);
         end
         chk(req_pending == 1'b0, "R3 pending cleared", req_pending, 0);
         if (mis) begin
            chk(err_dev == 1'b1 && cmd_start == 1'b0 && busy == 1'b0,
                "R2 device mismatch", {err_dev, cmd_start, busy}, 3'b100);
            held("R2 fields unchanged");
         end else begin
            chk(cmd_start == 1'b1 && busy == 1'b1 && !err_dev, "R3 start and busy",
                {cmd_start, busy}, 2'b11);
            e_op = w[0][4:0]; e_dev = w[0][7:5]; e_cnt = w[1];
            e_rba = exp_rba(s4, w[2], w[3]);
            chk(cmd_rba == e_rba, "R5 block address", cmd_rba, e_rba);
            held("R5 command fields");
         end
         if (s4) begin
            wr_word(16'($urandom));
            chk(err_overrun == 1'b1 && !cmd_start, "R4 fifth word", err_overrun, 1);
            held("R4 fields after fifth word");
         end
         status_round(int'($urandom % 16), 5'($urandom), 3'($urandom));
      end
      // Full-depth status block
      status_round(15, 5'h1f, 3'd7);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule